// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block takes configuration words from a slow three-wire serial bus and places each word in one of three parallel holding registers. The bus carries a shift clock, a data line and an active-low frame select. The bus lines are oversampled by a fast system clock. Each line passes through a two-flop synchronizer, and bus edges are found in the system clock domain. The bus clock is assumed to run at 330 kHz or less.

While the select line is low, a data bit is taken on every rising edge of the shift clock. When the select line goes high again, the last 14 bits received form one word. The two bits that arrived last are the register address, and the twelve bits before them are the payload. The addressed register loads the payload, and a one-cycle update strobe for that register goes out together with the new value. Downstream dividers can use the strobe to restart.

The receiver is a four-state machine:

- `RX_WAIT_HIGH`: the state after reset. The machine moves to `RX_IDLE` once the synchronized select is seen high.
- `RX_IDLE`: the machine moves to `RX_SHIFT` when select is low.
- `RX_SHIFT`: bits shift in on rising shift-clock edges. The machine moves to `RX_COMMIT` when select is high.
- `RX_COMMIT`: lasts exactly one cycle, issues the load, and returns to `RX_IDLE`.

Top module: `tw_cfg_bank`

## Requirements
- R1: After reset, every field output is zero and every strobe is low. Bus activity is ignored until the synchronized select has been seen high once. A frame clocked in before that point changes nothing.
- R2: A data bit is taken only on a rising edge of the shift clock while select is low. Shift-clock edges while select is high add no bits.
- R3: The bit count is never checked and only the 14 most recent bits form the word. Leading extra bits are dropped. A short frame completes its word with the newest bits left over from earlier frames. The shift register is zero at reset.
- R4: On the wire the payload comes first, most significant bit first (payload bit 11 first). It is followed by address bit 1, then address bit 0, which is the last bit.
- R5: Address 01 loads the reference register. Payload bits 9:8 drive `ref_mod_sel` and payload bits 7:0 drive `ref_conv_div`. Payload bits 11:10 are ignored.
- R6: Address 10 loads the control register. Payload bit 8 drives `ctl_out_on`: 1 enables the output and 0 disables it. Payload bits 7:5 drive `ctl_pump_sel` and payload bits 4:0 drive `ctl_gain`: 0 is the minimum gain and 31 is the maximum. Payload bits 11:9 are ignored.
- R7: Address 11 loads `main_div` from all twelve payload bits.
- R8: A word with address 00 changes no output and raises no strobe.
- R9: No register changes while select is low. The new value appears after the fourth rising system-clock edge that follows the select rising on the bus pin.
- R10: Each load raises exactly one strobe (`upd_ref`, `upd_ctl` or `upd_main`) for exactly one system-clock cycle. The strobe is high in the same cycle the new value first appears.
- R11: A load to one register leaves the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sck | input | 1 | Serial shift clock |
| ser_sdi | input | 1 | Serial data |
| ser_sel_n | input | 1 | Active-low frame select |
| ref_mod_sel | output | 2 | Modulator reference divider select |
| ref_conv_div | output | 8 | Converter reference divider ratio |
| ctl_out_on | output | 1 | Output enable setting |
| ctl_pump_sel | output | 3 | Charge-pump current select |
| ctl_gain | output | 5 | Gain code |
| main_div | output | 12 | Main divider ratio |
| upd_ref | output | 1 | One-cycle strobe on a reference register load |
| upd_ctl | output | 1 | One-cycle strobe on a control register load |
| upd_main | output | 1 | One-cycle strobe on a main divider load |

## Verification
Shift-clock edges that arrive while select is high are the hardest case to observe. A normal 14-bit frame overwrites every bit of the shift register, so any stray bits taken in between frames are hidden. The stimulus therefore sends a frame with address 00 to fill the shift register with known bits. It then pulses the shift clock with zeros while select is high, and closes with a six-bit frame. The resulting main divider value depends on the eight bits left over from the earlier frame, so any stray shift shows up as a wrong value. A second hard case is a frame clocked in before select has ever been high: the bench holds select low through reset and clocks in a complete word first.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;

    typedef enum logic [1:0] {
        RX_WAIT_HIGH = 2'd0,
        RX_IDLE      = 2'd1,
        RX_SHIFT     = 2'd2,
        RX_COMMIT    = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_REF  = 2'b01,
        SEL_CTL  = 2'b10,
        SEL_MAIN = 2'b11
    } reg_sel_t;

    localparam int FRAME_BITS = 14;
    localparam int ADDR_BITS  = 2;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tw_rx_fsm.sv
module tw_rx_fsm
    import tw_cfg_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS
) (
    input  logic               sys_clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               sel_n_s,
    output logic               load_en,
    output logic [FRAME_W-1:0] word
);

    rx_state_t          state_q, state_d;
    logic               sck_d;
    logic               shift_en;
    logic [FRAME_W-1:0] shift_q;

    // state register
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_WAIT_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT_HIGH: if (sel_n_s)  state_d = RX_IDLE;
            RX_IDLE:      if (!sel_n_s) state_d = RX_SHIFT;
            RX_SHIFT:     if (sel_n_s)  state_d = RX_COMMIT;
            RX_COMMIT:                  state_d = RX_IDLE;
            default:                    state_d = RX_WAIT_HIGH;
        endcase
    end

    // outputs of the machine
    always_comb begin
        load_en  = (state_q == RX_COMMIT);
        shift_en = (state_q == RX_SHIFT) && !sel_n_s && sck_s && !sck_d;
    end

    // datapath: edge history and shift register
    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            shift_q <= '0;
        end else begin
            sck_d <= sck_s;
            if (shift_en) begin
                shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
            end
        end
    end

    assign word = shift_q;

    // R9
    commit_after_shift_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (state_q == RX_COMMIT) |-> ($past(state_q) == RX_SHIFT));

    // R10
    load_single_cycle_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        load_en |=> !load_en);

    // R2
    shift_only_in_frame_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (state_q != RX_SHIFT) |=> $stable(shift_q));

endmodule

// File: rtl/tw_reg_file.sv
module tw_reg_file
    import tw_cfg_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int ADDR_W  = ADDR_BITS
) (
    input  logic               sys_clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] word,
    output logic [1:0]         ref_mod_sel,
    output logic [7:0]         ref_conv_div,
    output logic               ctl_out_on,
    output logic [2:0]         ctl_pump_sel,
    output logic [4:0]         ctl_gain,
    output logic [11:0]        main_div,
    output logic               upd_ref,
    output logic               upd_ctl,
    output logic               upd_main
);

    localparam int PAY_W    = FRAME_W - ADDR_W;
    localparam int MODS_LSB = 8;
    localparam int OUTE_BIT = 8;
    localparam int PUMP_LSB = 5;

    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  pay;

    assign addr = word[ADDR_W-1:0];
    assign pay  = word[FRAME_W-1:ADDR_W];

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_mod_sel  <= '0;
            ref_conv_div <= '0;
            ctl_out_on   <= 1'b0;
            ctl_pump_sel <= '0;
            ctl_gain     <= '0;
            main_div     <= '0;
            upd_ref      <= 1'b0;
            upd_ctl      <= 1'b0;
            upd_main     <= 1'b0;
        end else begin
            upd_ref  <= 1'b0;
            upd_ctl  <= 1'b0;
            upd_main <= 1'b0;
            if (load_en) begin
                unique case (reg_sel_t'(addr))
                    SEL_REF: begin
                        ref_mod_sel  <= pay[MODS_LSB+1:MODS_LSB];
                        ref_conv_div <= pay[7:0];
                        upd_ref      <= 1'b1;
                    end
                    SEL_CTL: begin
                        ctl_out_on   <= pay[OUTE_BIT];
                        ctl_pump_sel <= pay[PUMP_LSB+2:PUMP_LSB];
                        ctl_gain     <= pay[4:0];
                        upd_ctl      <= 1'b1;
                    end
                    SEL_MAIN: begin
                        main_div <= pay[11:0];
                        upd_main <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    strobe_onehot_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        $onehot0({upd_ref, upd_ctl, upd_main}));

    // R11
    main_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !upd_main |-> $stable(main_div));

    // R11
    ref_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !upd_ref |-> ($stable(ref_conv_div) && $stable(ref_mod_sel)));

    // R8
    null_addr_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (load_en && (addr == '0)) |=> !(upd_ref || upd_ctl || upd_main));

endmodule

// File: rtl/tw_cfg_bank.sv
module tw_cfg_bank
    import tw_cfg_pkg::*;
#(
    parameter int FRAME_W     = FRAME_BITS,
    parameter int ADDR_W      = ADDR_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic        sys_clk,
    input  logic        rst_n,
    input  logic        ser_sck,
    input  logic        ser_sdi,
    input  logic        ser_sel_n,
    output logic [1:0]  ref_mod_sel,
    output logic [7:0]  ref_conv_div,
    output logic        ctl_out_on,
    output logic [2:0]  ctl_pump_sel,
    output logic [4:0]  ctl_gain,
    output logic [11:0] main_div,
    output logic        upd_ref,
    output logic        upd_ctl,
    output logic        upd_main
);

    logic [2:0]         bus_s;
    logic               load_en;
    logic [FRAME_W-1:0] word;

    tw_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b000)
    ) u_sync (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .d       ({ser_sel_n, ser_sdi, ser_sck}),
        .q       (bus_s)
    );

    tw_rx_fsm #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .sck_s   (bus_s[0]),
        .sdi_s   (bus_s[1]),
        .sel_n_s (bus_s[2]),
        .load_en (load_en),
        .word    (word)
    );

    tw_reg_file #(
        .FRAME_W (FRAME_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .sys_clk      (sys_clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .word         (word),
        .ref_mod_sel  (ref_mod_sel),
        .ref_conv_div (ref_conv_div),
        .ctl_out_on   (ctl_out_on),
        .ctl_pump_sel (ctl_pump_sel),
        .ctl_gain     (ctl_gain),
        .main_div     (main_div),
        .upd_ref      (upd_ref),
        .upd_ctl      (upd_ctl),
        .upd_main     (upd_main)
    );

endmodule

// File: tb/tw_cfg_bank_tb.sv
module tw_cfg_bank_tb;

    logic sys_clk = 1'b0;
    always #5 sys_clk = ~sys_clk;

    logic        rst_n;
    logic        ser_sck, ser_sdi, ser_sel_n;
    logic [1:0]  ref_mod_sel;
    logic [7:0]  ref_conv_div;
    logic        ctl_out_on;
    logic [2:0]  ctl_pump_sel;
    logic [4:0]  ctl_gain;
    logic [11:0] main_div;
    logic        upd_ref, upd_ctl, upd_main;

    tw_cfg_bank u_dut (
        .sys_clk(sys_clk), .rst_n(rst_n),
        .ser_sck(ser_sck), .ser_sdi(ser_sdi), .ser_sel_n(ser_sel_n),
        .ref_mod_sel(ref_mod_sel), .ref_conv_div(ref_conv_div),
        .ctl_out_on(ctl_out_on), .ctl_pump_sel(ctl_pump_sel), .ctl_gain(ctl_gain),
        .main_div(main_div),
        .upd_ref(upd_ref), .upd_ctl(upd_ctl), .upd_main(upd_main)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference model
    logic [1:0]  e_mod;
    logic [7:0]  e_conv;
    logic        e_on;
    logic [2:0]  e_pump;
    logic [4:0]  e_gain;
    logic [11:0] e_main;
    logic        e_uref, e_uctl, e_umain;
    bit          m_armed, m_inframe, m_pend;
    logic [13:0] m_word;
    logic [2:0]  h_sel, h_sck, h_sdi;

    always @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) begin
            e_mod = 0; e_conv = 0; e_on = 0; e_pump = 0; e_gain = 0; e_main = 0;
            e_uref = 0; e_uctl = 0; e_umain = 0;
            m_armed = 0; m_inframe = 0; m_pend = 0; m_word = 0;
            h_sel = 0; h_sck = 0; h_sdi = 0;
        end else begin
            e_uref = 0; e_uctl = 0; e_umain = 0;
            if (m_pend) begin
                m_pend = 0;
                case (m_word[1:0])
                    2'b01: begin e_mod = m_word[11:10]; e_conv = m_word[9:2]; e_uref = 1; end
                    2'b10: begin e_on = m_word[10]; e_pump = m_word[9:7];
                                 e_gain = m_word[6:2]; e_uctl = 1; end
                    2'b11: begin e_main = m_word[13:2]; e_umain = 1; end
                    default: ;
                endcase
            end else if (!m_armed) begin
                if (h_sel[1]) m_armed = 1;
            end else if (!m_inframe) begin
                if (!h_sel[1]) m_inframe = 1;
            end else if (h_sel[1]) begin
                m_inframe = 0;
                m_pend    = 1;
            end else if (h_sck[1] && !h_sck[2]) begin
                m_word = {m_word[12:0], h_sdi[1]};
            end
            h_sel = {h_sel[1:0], ser_sel_n};
            h_sck = {h_sck[1:0], ser_sck};
            h_sdi = {h_sdi[1:0], ser_sdi};
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge sys_clk) begin
        if (!done) begin
            chk({14'd0, ref_mod_sel}, {14'd0, e_mod},  "R5 ref_mod_sel");
            chk({8'd0, ref_conv_div}, {8'd0, e_conv},  "R5 ref_conv_div");
            chk({15'd0, ctl_out_on},  {15'd0, e_on},   "R6 ctl_out_on");
            chk({13'd0, ctl_pump_sel},{13'd0, e_pump}, "R6 ctl_pump_sel");
            chk({11'd0, ctl_gain},    {11'd0, e_gain}, "R6 ctl_gain");
            chk({4'd0, main_div},     {4'd0, e_main},  "R7 main_div");
            chk({13'd0, upd_ref, upd_ctl, upd_main},
                {13'd0, e_uref, e_uctl, e_umain}, "R10 strobes");
        end
    end

    int c_ref = 0, c_ctl = 0, c_main = 0;
    always @(negedge sys_clk) begin
        if (upd_ref)  c_ref++;
        if (upd_ctl)  c_ctl++;
        if (upd_main) c_main++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        ser_sel_n = 1'b0;
        wait_cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_sdi = v[i];
            wait_cyc(3);
            ser_sck = 1'b1;
            wait_cyc(3);
            ser_sck = 1'b0;
        end
        wait_cyc(3);
    endtask

    task automatic end_frame();
        ser_sel_n = 1'b1;
        wait_cyc(8);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int r_before, c_before, m_before;
        rst_n = 1'b0; ser_sck = 1'b0; ser_sdi = 1'b0; ser_sel_n = 1'b0;
        wait_cyc(4);
        chk({4'd0, main_div}, 16'd0, "R1 reset main");
        chk({13'd0, upd_ref, upd_ctl, upd_main}, 16'd0, "R1 reset strobes");
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: frame before select ever seen high is ignored
        send_bits({18'd0, 12'h7E1, 2'b11}, 14);
        end_frame();
        chk({4'd0, main_div}, 16'd0, "R1 pre-arm frame ignored");

        // R7 / R4: main register, first bit is payload MSB
        send_bits({18'd0, 12'hA5C, 2'b11}, 14);
        end_frame();
        chk({4'd0, main_div}, 16'h0A5C, "R7 R4 main load");

        // R5: reference register, don't-care bits set
        send_bits({18'd0, 2'b11, 2'b10, 8'h3C, 2'b01}, 14);
        end_frame();
        chk({14'd0, ref_mod_sel}, 16'd2, "R5 mod select");
        chk({8'd0, ref_conv_div}, 16'h3C, "R5 conv ratio");

        // R6 / R11: control register, main unchanged
        send_bits({18'd0, 3'b111, 1'b1, 3'b101, 5'b10011, 2'b10}, 14);
        end_frame();
        chk({15'd0, ctl_out_on}, 16'd1, "R6 out on");
        chk({13'd0, ctl_pump_sel}, 16'd5, "R6 pump");
        chk({11'd0, ctl_gain}, 16'h13, "R6 gain");
        chk({4'd0, main_div}, 16'h0A5C, "R11 main held");
        chk({8'd0, ref_conv_div}, 16'h3C, "R11 ref held");

        // R3: 20-bit frame, six leading bits dropped
        send_bits({12'd0, 6'b111111, 12'h0F1, 2'b11}, 20);
        end_frame();
        chk({4'd0, main_div}, 16'h00F1, "R3 long frame");

        // R8: address 00 changes nothing
        r_before = c_ref; c_before = c_ctl; m_before = c_main;
        send_bits({18'd0, 12'hFFF, 2'b00}, 14);
        end_frame();
        chk({4'd0, main_div}, 16'h00F1, "R8 main kept");
        chk({11'd0, ctl_gain}, 16'h13, "R8 gain kept");
        chk({8'd0, ref_conv_div}, 16'h3C, "R8 ref kept");
        chk(16'(c_ref + c_ctl + c_main - r_before - c_before - m_before), 16'd0, "R8 no strobe");

        // R2: shift-clock pulses while select high add nothing
        for (int i = 0; i < 16; i++) begin
            ser_sdi = 1'b0; wait_cyc(3); ser_sck = 1'b1; wait_cyc(3); ser_sck = 1'b0;
        end
        wait_cyc(4);
        chk({4'd0, main_div}, 16'h00F1, "R2 idle pulses no load");
        // R3: short frame reuses leftover bits 11111100
        send_bits({26'd0, 6'b101011}, 6);
        end_frame();
        chk({4'd0, main_div}, 16'h0FCA, "R2 R3 short frame with leftovers");

        // R9 / R10: no change before select rises, single strobe after
        r_before = c_ref; c_before = c_ctl; m_before = c_main;
        send_bits({18'd0, 12'h123, 2'b11}, 14);
        wait_cyc(10);
        chk({4'd0, main_div}, 16'h0FCA, "R9 held while select low");
        end_frame();
        chk({4'd0, main_div}, 16'h0123, "R9 loaded after select high");
        chk(16'(c_main - m_before), 16'd1, "R10 one main strobe");
        chk(16'(c_ref + c_ctl - r_before - c_before), 16'd0, "R10 no other strobe");

        // R6: gain extremes and output disable
        send_bits({18'd0, 3'b000, 1'b0, 3'b000, 5'b11111, 2'b10}, 14);
        end_frame();
        chk({11'd0, ctl_gain}, 16'h1F, "R6 max gain");
        chk({15'd0, ctl_out_on}, 16'd0, "R6 output disabled");

        wait_cyc(4);
        finish_run();
    end

endmodule